// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns a fixed crystal clock into the enable tick that paces a UART's bit timing or oversampling. A 32-bit configuration word, loaded through a write strobe, chooses the path the clock takes. One flag picks the crystal as the source. Two more flags pick a crystal pre-divide of 3, 2 or 1. A further flag chooses between a wide 23-bit divisor carried in the word itself and a narrower legacy divisor supplied on a separate input.

The pre-divider is a clock-enable counter, so every register runs on the one input clock. Its enable steps a reload down-counter, which puts out a one-cycle tick each time it passes zero. A write restarts both the pre-divider and the down-counter. The first tick after a write therefore lands exactly one full period later. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset loads the configuration word with crystal source on (bit 24), wide divisor path on (bit 23), pre-divide flags at zero and divisor 0. After reset release, ticks therefore repeat every 3 clock cycles.
- R2: With the wide path on, the tick period is D*(N+1) clock cycles. N is bits 22:0 of the configuration word and D is the pre-divide factor. Bits 31:28 and 25 have no effect.
- R3: With bit 24 set and bits 27 and 26 both clear, D = 3.
- R4: With bit 24 set, bit 26 set and bit 27 clear, D = 1.
- R5: With bit 24 set and bit 27 set, D = 2 whatever bit 26 holds.
- R6: With bit 24 clear, D = 1 and bits 27 and 26 have no effect.
- R7: With bit 23 clear, the period is D*(L+1). L is the legacy divisor input, and bits 22:0 have no effect.
- R8: A write restarts the timing. The first tick is visible in the cycle that follows the D*(N+1)-th rising edge counted from the edge that samples the write.
- R9: When D*(N+1) > 1, each tick lasts one cycle. When D = 1 and N = 0, the tick is high in every cycle.
- R10: While reset is asserted the tick output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | 32 | Configuration word (flags and divisor) |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| legacy_div_i | input | LEGACY_W | Divisor used when the wide path is off |
| tick_o | output | 1 | Single-cycle tick enable |

## Verification
The hardest case to bring about is the phase relation between a write and the running pre-divider and counter. A write that lands mid-count must discard both partial counts, or the first tick comes early. The bench writes new words while a previous, longer setting is still counting down. It then measures the latency from the write edge to the first tick separately from the period that follows. The flag priority (bit 27 over bit 26, bit 24 clear masking both) is reached by writing words that set the competing flags together.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int CFG_W      = 32;
  localparam int DIV_W      = 23;
  localparam int BIT_XTAL   = 24;
  localparam int BIT_WIDE   = 23;
  localparam int BIT_NODIV  = 26;
  localparam int BIT_HALF   = 27;
  localparam int PRE_W      = 2;

  typedef enum logic [1:0] {
    PRE_BY1 = 2'd0,
    PRE_BY2 = 2'd1,
    PRE_BY3 = 2'd2
  } pre_sel_e;

  localparam logic [CFG_W-1:0] CFG_RESET =
    (CFG_W'(1) << BIT_XTAL) | (CFG_W'(1) << BIT_WIDE);

  function automatic pre_sel_e decode_pre(input logic [CFG_W-1:0] w);
    if (!w[BIT_XTAL])      return PRE_BY1;
    else if (w[BIT_HALF])  return PRE_BY2;
    else if (w[BIT_NODIV]) return PRE_BY1;
    else                   return PRE_BY3;
  endfunction

  function automatic logic [PRE_W-1:0] pre_last(input pre_sel_e s);
    case (s)
      PRE_BY2: return PRE_W'(1);
      PRE_BY3: return PRE_W'(2);
      default: return PRE_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

  // R10: the internal reset never releases while the pin holds reset
  always_comb begin
    if (!rst_n_i) a_r10_sync_held: assert (sync_q == '0 || $isunknown(sync_q));
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] last_i,
  output logic             en_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic             cnt_ce;

  assign en_o = (cnt_q == last_i);

  always_comb begin
    cnt_ce = 1'b1;
    if (restart_i)  cnt_d = '0;
    else if (en_o)  cnt_d = '0;
    else            cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R3: the phase counter stays within the selected divide range
  a_r3_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= last_i);

  // R5: with a divide above one, enables never come in consecutive cycles
  a_r5_enable_spacing: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_o && last_i != '0 && !restart_i) |=> !en_o);
endmodule

// File: rtl/baud_reload_counter.sv
module baud_reload_counter #(
  parameter int DIV_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick_q;
  logic             tick_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (restart_i) begin
      cnt_d = reload_i;
    end else if (en_i) begin
      if (at_zero) begin
        cnt_d  = reload_i;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R8: a write loads the new reload value into the counter
  a_r8_reload_on_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> cnt_q == $past(reload_i));

  // R9: a tick only follows a cycle in which the pre-divided enable was high
  a_r9_tick_after_enable: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_o |-> $past(en_i));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int LEGACY_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [31:0]         cfg_word_i,
  input  logic                cfg_wr_i,
  input  logic [LEGACY_W-1:0] legacy_div_i,
  output logic                tick_o
);
  logic             rst_n;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_nxt;
  logic             cfg_ce;
  logic [DIV_W-1:0] reload;
  logic [PRE_W-1:0] last;
  logic             pre_en;
  pre_sel_e         sel;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  assign cfg_ce  = cfg_wr_i;
  assign cfg_nxt = cfg_ce ? cfg_word_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_ce) cfg_q <= cfg_word_i;
  end

  always_comb begin
    sel  = decode_pre(cfg_q);
    last = pre_last(sel);
    if (cfg_nxt[BIT_WIDE]) reload = cfg_nxt[DIV_W-1:0];
    else                   reload = DIV_W'(legacy_div_i);
  end

  baud_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .restart_i (cfg_wr_i),
    .last_i    (last),
    .en_o      (pre_en)
  );

  baud_reload_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .restart_i (cfg_wr_i),
    .en_i      (pre_en),
    .reload_i  (reload),
    .tick_o    (tick_o)
  );

  // R1: the configuration register comes out of reset with its defaults
  a_r1_reset_default: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_q == CFG_RESET);

  // R10: no tick while the internal reset is active
  always_comb begin
    if (!rst_n) a_r10_quiet_in_reset: assert (tick_o == 1'b0 || $isunknown(tick_o));
  end
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   word = '0;
  logic          wr = 1'b0;
  logic [LW-1:0] legacy = LW'(5);
  logic          tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen #(.LEGACY_W(LW)) dut (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .cfg_word_i   (word),
    .cfg_wr_i     (wr),
    .legacy_div_i (legacy),
    .tick_o       (tick)
  );

  localparam logic [31:0] F_XTAL = 32'h0100_0000;
  localparam logic [31:0] F_WIDE = 32'h0080_0000;
  localparam logic [31:0] F_NODV = 32'h0400_0000;
  localparam logic [31:0] F_HALF = 32'h0800_0000;
  localparam logic [31:0] F_JUNK = 32'hF200_0000;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count rising edges until tick is seen at a falling edge
  task automatic edges_to_tick(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tick) return;
    end
    n = -1;
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    word = w; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  // write then measure latency, width and period
  task automatic run_case(input string req, input logic [31:0] w, input int exp);
    int n;
    @(negedge clk);
    word = w; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
    edges_to_tick(n);
    chk({req, " latency"}, n, exp);
    if (exp > 1) begin
      @(posedge clk); @(negedge clk);
      chk("R9 width", int'(tick), 0);
      edges_to_tick(n);
      chk({req, " period"}, n + 1, exp);
    end else begin
      edges_to_tick(n);
      chk({req, " period"}, n, exp);
    end
  endtask

  task automatic t_reset;
    int n;
    rst_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 low in reset", int'(tick), 0);
    end
    rst_n = 1'b1;
    edges_to_tick(n);
    edges_to_tick(n);
    chk("R1 default period", n, 3);
    edges_to_tick(n);
    chk("R1 default period again", n, 3);
  endtask

  task automatic t_divides;
    run_case("R3 div3 N=4", F_XTAL | F_WIDE | 32'd4, 15);
    run_case("R4 div1 N=6", F_XTAL | F_WIDE | F_NODV | 32'd6, 7);
    run_case("R5 div2 N=3", F_XTAL | F_WIDE | F_HALF | 32'd3, 8);
    run_case("R5 div2 over nodiv", F_XTAL | F_WIDE | F_HALF | F_NODV | 32'd3, 8);
    run_case("R6 no xtal ignores flags", F_WIDE | F_HALF | 32'd5, 6);
  endtask

  task automatic t_wide;
    run_case("R2 junk bits ignored", F_JUNK | F_XTAL | F_WIDE | 32'd2, 9);
    run_case("R2 large N", F_XTAL | F_WIDE | 32'd1000, 3003);
    run_case("R9 every cycle", F_XTAL | F_WIDE | F_NODV | 32'd0, 1);
  endtask

  task automatic t_legacy;
    run_case("R7 legacy div1", F_XTAL | F_NODV | 32'd7, 6);
    run_case("R7 legacy div3", F_XTAL | 32'h7F_FFFF, 18);
  endtask

  task automatic t_restart;
    int n;
    write_word(F_XTAL | F_WIDE | 32'd200);
    repeat (137) @(posedge clk);
    run_case("R8 restart mid count", F_XTAL | F_WIDE | F_HALF | 32'd4, 10);
  endtask

  initial begin
    t_reset();
    t_divides();
    t_wide();
    t_legacy();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule